// File: doc/BRIEF.md
# Dual-Mode Asynchronous Host Bus Interface

This block is the slave side of a parallel processor bus. It lets an asynchronous host read and write a bank of 256 eight-bit registers kept inside the block. One static pin, `modeSel`, decides how the host strobes are read. With `modeSel` low, the host drives a separate active-low read strobe and a separate active-low write strobe. With `modeSel` high, the host drives one active-low data strobe together with a direction level, where high means read and low means write. In both modes the bus also carries an address-latch strobe, an active-low chip select, an 8-bit address, an 8-bit data path (a split in/out pair with an output enable) and an active-low ready output.

Every host input passes through a two-flop synchronizer into the single internal clock. The address follows the address bus while the latch strobe is high and freezes when the strobe falls. A recognised strobe starts exactly one register access. Ready then goes low and stays low until the host releases the strobe or chip select. On a read, the output enable is raised with the addressed value while ready is low.

Top module: `hbi_top`

## Requirements
- R1: After reset, `readyN` is high and `dataOe` is low.
- R2: The register address is the value of `addrIn` at the time the latch strobe `ale` was last high before it fell. Changes to `addrIn` while `ale` is low do not change which register is accessed.
- R3: While `csN` is high, no strobe starts an access. No register is written and `readyN` stays high.
- R4: With `modeSel` = 0, `wrN` going low while `csN` is low writes `dataIn` into the addressed register.
- R5: With `modeSel` = 0, `rdN` going low while `csN` is low raises `dataOe` and drives the addressed register's value on `dataOut`, and that value holds while `dataOe` stays high.
- R6: With `modeSel` = 1, `rdN` (the data strobe) going low with `wrN` (the direction level) low and `csN` low writes `dataIn` into the addressed register.
- R7: With `modeSel` = 1, the data strobe going low with the direction level high and `csN` low is a read. `dataOe` is high and `dataOut` carries the addressed register.
- R8: Once an access completes, `readyN` goes low and stays low until the strobe or `csN` returns high. After that, `readyN` is high and `dataOe` is low.
- R9: A strobe held low performs one access only. A write stores the data present when the strobe was first recognised.
- R10: `dataOe` is never raised during a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 1 | 0: separate read/write strobes; 1: data strobe plus direction |
| csN | input | 1 | Active-low chip select |
| ale | input | 1 | Address-latch strobe, active high, latches on its fall |
| addrIn | input | 8 | Register address |
| rdN | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wrN | input | 1 | Write strobe (mode 0) or direction, 1 = read (mode 1) |
| dataIn | input | 8 | Write data from the host |
| dataOut | output | 8 | Read data to the host |
| dataOe | output | 1 | Enable for the host data bus driver |
| readyN | output | 1 | Active-low cycle-complete acknowledge |

## Verification
The assertions check several rules on every cycle. A synchronized high chip select forces ready high and the output enable low on the next cycle. An idle controller with chip select high stays idle. A write strobe to the register bank lasts a single cycle and is followed by an acknowledge. The latched address and the driven read data do not move while their hold conditions apply. Other properties need the host's side of the protocol, so only the directed scenarios can show them: that the right register receives the right byte in each mode, that the latch ignores address changes after its strobe falls, and that a long-held strobe stores the first data only. The bench checks these by reading back against a behavioural model of the register bank.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WRITE = 2'd1,
    S_READ  = 2'd2,
    S_DONE  = 2'd3
  } hbiState_t;

  typedef struct packed {
    logic wrEn;
    logic rdLoad;
    logic oe;
  } hbiCtl_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= RESET_VAL;
      syncOut <= RESET_VAL;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeSel,
  input  logic    csSync,
  input  logic    rdSync,
  input  logic    wrSync,
  output hbiCtl_t ctl,
  output logic    readyN
);
  hbiState_t state, nextState;
  logic      readCycle;
  logic      strobeLow;
  logic      wantRead;

  // Mode 0: either strobe low starts a cycle. Mode 1: the data strobe starts it and wrSync gives direction.
  always_comb begin
    strobeLow = modeSel ? !rdSync : (!rdSync || !wrSync);
    wantRead  = modeSel ? wrSync  : !rdSync;
  end

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:  if (!csSync && strobeLow) nextState = wantRead ? S_READ : S_WRITE;
      S_WRITE: nextState = csSync ? S_IDLE : S_DONE;
      S_READ:  nextState = csSync ? S_IDLE : S_DONE;
      S_DONE:  if (csSync || !strobeLow) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      readCycle <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && nextState != S_IDLE) readCycle <= wantRead;
    end
  end

  always_comb begin
    ctl.wrEn   = (state == S_WRITE);
    ctl.rdLoad = (state == S_READ);
    ctl.oe     = (state == S_DONE) && readCycle;
    readyN     = !(state == S_DONE);
  end

  // R3, R8: a released chip select drops the acknowledge and the driver next cycle
  p_cs_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> (readyN && !ctl.oe));

  // R3: no cycle starts while chip select is high
  p_no_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && csSync) |=> (state == S_IDLE));

  // R9: a write pulse to the bank lasts one cycle
  p_single_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> !ctl.wrEn);

  // R4, R10: a write with chip select held is acknowledged without driving the bus
  p_write_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && !csSync) |=> (!readyN && !ctl.oe));
endmodule

// File: rtl/hbi_datapath.sv
module hbi_datapath
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aleSync,
  input  logic [ADDR_W-1:0] addrSync,
  input  logic [DATA_W-1:0] dataSync,
  input  hbiCtl_t           ctl,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrLatch;
  logic [DATA_W-1:0] regBank [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrLatch <= '0;
    else if (aleSync) addrLatch <= addrSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regBank[i] <= '0;
    end else if (ctl.wrEn) begin
      regBank[addrLatch] <= dataSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= '0;
    else if (ctl.rdLoad) dataOut <= regBank[addrLatch];
  end

  // R2: the latched address is frozen while the latch strobe is low
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !aleSync |=> $stable(addrLatch));

  // R5: driven read data does not move while the driver stays on
  p_read_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.oe && $past(ctl.oe)) |-> $stable(dataOut));
endmodule

// File: rtl/hbi_top.sv
module hbi_top
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              csN,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              readyN
);
  logic [3:0]        ctlSync;
  logic [ADDR_W-1:0] addrSync;
  logic [DATA_W-1:0] dataSync;
  hbiCtl_t           ctl;

  hbi_sync #(.WIDTH(4), .RESET_VAL(4'b1110)) u_syncCtl (
    .clk(clk), .rstN(rstN), .asyncIn({csN, rdN, wrN, ale}), .syncOut(ctlSync));
  hbi_sync #(.WIDTH(ADDR_W)) u_syncAddr (
    .clk(clk), .rstN(rstN), .asyncIn(addrIn), .syncOut(addrSync));
  hbi_sync #(.WIDTH(DATA_W)) u_syncData (
    .clk(clk), .rstN(rstN), .asyncIn(dataIn), .syncOut(dataSync));

  hbi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .csSync(ctlSync[3]), .rdSync(ctlSync[2]), .wrSync(ctlSync[1]),
    .ctl(ctl), .readyN(readyN));

  hbi_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .aleSync(ctlSync[0]), .addrSync(addrSync),
    .dataSync(dataSync), .ctl(ctl), .dataOut(dataOut));

  assign dataOe = ctl.oe;
endmodule

// File: tb/hbi_top_test.sv
module hbi_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSel = 1'b0;
  logic       csN = 1'b1;
  logic       ale = 1'b0;
  logic [7:0] addrIn = '0;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;
  logic       readyN;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] model [256];

  hbi_top uut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic latchAddr(input logic [7:0] a);
    addrIn = a; csN = 1'b0; ale = 1'b1;
    tick(4);
    ale = 1'b0;
    tick(4);
    addrIn = ~a;   // R2: later address changes must be ignored
  endtask

  task automatic waitReady(input string req, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      tick(1);
      if (!readyN) seen = 1'b1;
    end
    check(seen, req, readyN, 0);
  endtask

  task automatic releaseBus(input string req);
    rdN = 1'b1; wrN = 1'b1;
    tick(5);
    check(readyN && !dataOe, req, {readyN, dataOe}, 2'b10);
    csN = 1'b1;
    tick(4);
  endtask

  task automatic doWrite(input bit mode, input logic [7:0] a, input logic [7:0] d);
    bit seen;
    modeSel = mode;
    latchAddr(a);
    dataIn = d;
    tick(3);
    if (mode) begin wrN = 1'b0; rdN = 1'b0; end
    else wrN = 1'b0;
    waitReady(mode ? "R6" : "R4", seen);
    check(!dataOe, "R10", dataOe, 0);
    model[a] = d;
    releaseBus("R8");
  endtask

  task automatic doRead(input bit mode, input logic [7:0] a, input string req);
    bit seen;
    modeSel = mode;
    latchAddr(a);
    if (mode) begin wrN = 1'b1; rdN = 1'b0; end
    else rdN = 1'b0;
    waitReady(req, seen);
    tick(1);
    check(dataOe, req, dataOe, 1);
    check(dataOut == model[a], req, dataOut, model[a]);
    releaseBus("R8");
  endtask

  task automatic testReset();
    check(readyN == 1'b1, "R1", readyN, 1);
    check(dataOe == 1'b0, "R1", dataOe, 0);
  endtask

  task automatic testSeparateStrobes();
    doWrite(1'b0, 8'h00, 8'h5A);
    doWrite(1'b0, 8'hFF, 8'hC3);
    doWrite(1'b0, 8'h42, 8'h81);
    doRead(1'b0, 8'h00, "R5");
    doRead(1'b0, 8'hFF, "R5");
    doRead(1'b0, 8'h42, "R2");
    doRead(1'b0, 8'h17, "R5");
  endtask

  task automatic testStrobeDirection();
    doWrite(1'b1, 8'h10, 8'h3C);
    doWrite(1'b1, 8'h80, 8'hE7);
    doRead(1'b1, 8'h10, "R7");
    doRead(1'b1, 8'h80, "R7");
    doRead(1'b1, 8'hFF, "R7");
  endtask

  task automatic testNoSelect();
    bit sawReady = 1'b0;
    modeSel = 1'b0;
    latchAddr(8'h42);
    csN = 1'b1;
    dataIn = 8'h11;
    tick(2);
    wrN = 1'b0;
    for (int i = 0; i < 15; i++) begin
      tick(1);
      if (!readyN) sawReady = 1'b1;
    end
    check(!sawReady, "R3", sawReady, 0);
    wrN = 1'b1;
    tick(4);
    doRead(1'b0, 8'h42, "R3");
  endtask

  task automatic testHeldStrobe();
    bit seen;
    modeSel = 1'b0;
    latchAddr(8'h33);
    dataIn = 8'hA5;
    tick(3);
    wrN = 1'b0;
    waitReady("R9", seen);
    dataIn = 8'h0F;
    tick(10);
    check(!readyN, "R8", readyN, 0);
    model[8'h33] = 8'hA5;
    releaseBus("R8");
    doRead(1'b0, 8'h33, "R9");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    tick(3);
    testReset();
    rstN = 1'b1;
    tick(3);
    testReset();
    testSeparateStrobes();
    testStrobeDirection();
    testNoSelect();
    testHeldStrobe();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule